// File: doc/BRIEF.md
# Two-Wire Serial Slave Engine

This block is the bus-facing protocol engine of a serial memory that sits on a two-wire, open-drain bus. A fast system clock oversamples the serial clock and data lines. The engine finds start and stop conditions, shifts bytes in and out, and matches the header byte against a fixed device type code and three strap pins. It takes a two-byte word address and acknowledges each accepted byte by pulling the data line low. In read transfers it sends data and watches the master's acknowledge. It never drives the line high: its only output toward the bus is an enable that pulls the data line low.

Toward the memory, the engine produces one-cycle strobes. One loads a new word address. One hands over a received data byte. One asks for the next read byte, which must be present on the read-data input one clock later. One, the commit, starts the internal write cycle. The memory side owns the address counter and its wrap rules. While the memory reports that an internal write cycle is running, the engine leaves the line released and does not acknowledge its header, so a master can poll for completion.

Top module: `tw_slave_engine`

## Requirements
- R1: A start condition (data falling while the clock is high) at any point, including in the middle of a transfer, abandons that transfer and begins matching a new header. A stop condition (data rising while the clock is high) returns the engine to idle.
- R2: The header byte is sent MSB first. Bits 7:4 must equal 4'b1010. Bits 3:1 must equal `sel_i[2:0]`, with `sel_i[2]` compared to bit 3. Bit 0 selects the direction: 1 is read, 0 is write. A matching header is acknowledged by asserting `sda_oe_o` through the ninth clock.
- R3: A header that does not match gets no acknowledge. Every later byte is also left unacknowledged until the next start.
- R4: After a write header, the first byte supplies address bits 13:8 from its bits 5:0; its bits 7:6 are discarded. The second byte supplies address bits 7:0. Both bytes are acknowledged. After the second byte, `ld_stb_o` pulses once with the full address on `ld_addr_o`.
- R5: Every later byte of a write transfer is acknowledged. Each one gives a single `wr_stb_o` pulse with the byte on `wr_data_o`.
- R6: `commit_o` pulses once on a stop, and only when at least one data byte was received since the last start. A transfer that only sets the address, a read, and a write that is ended by a repeated start give no commit.
- R7: In a read, each byte is requested with one `rd_req_o` pulse and sent MSB first. `sda_oe_o` is low (line released) during the master's acknowledge clock.
- R8: When the master acknowledges, the next byte follows. When it does not, the engine releases the line, sends nothing more and requests nothing more until the next start.
- R9: While `busy_i` is high, a matching header is not acknowledged and `sda_oe_o` stays low.
- R10: `sda_oe_o` changes only while the synchronised serial clock is low.
- R11: No two of `ld_stb_o`, `wr_stb_o`, `rd_req_o` and `commit_o` are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, as seen on the bus |
| sda_i | input | 1 | Serial data line, resolved bus value |
| sel_i | input | 3 | Strap pins compared with header bits 3:1 |
| busy_i | input | 1 | Internal write cycle in progress |
| rd_data_i | input | 8 | Read byte, valid one cycle after `rd_req_o` |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| ld_stb_o | output | 1 | Address-load strobe |
| ld_addr_o | output | 14 | Word address that goes with `ld_stb_o` |
| wr_stb_o | output | 1 | Data-byte write strobe |
| wr_data_o | output | 8 | Byte that goes with `wr_stb_o` |
| rd_req_o | output | 1 | Request for the next read byte |
| commit_o | output | 1 | Start of the internal write cycle |

## Verification
The assertions assume a legal bus. The master changes the data line only while the clock is low, except when it makes a start or a stop. It never tries a start or a stop while the engine is pulling the line low. It raises `busy_i` only after a commit, while the bus is idle. The bench master holds every clock phase for many system clocks, so both lines are stable through the synchroniser when the engine samples them. It changes data a few cycles after each clock fall, and it models the bus as the AND of its own drive and the engine's release. The memory model answers a read request one cycle later and raises busy only in response to a commit.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT, ST_HOLD
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic hdr_match(input logic [BYTE_W-1:0] b,
                                       input logic [SEL_W-1:0] sel);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
    endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
    import tw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_q,
    input  logic    sda_q,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    always_comb begin
        ev.start = scl_q & scl_p & sda_p & ~sda_q;
        ev.stop  = scl_q & scl_p & ~sda_p & sda_q;
        ev.rise  = scl_q & ~scl_p;
        ev.fall  = ~scl_q & scl_p;
    end
endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
    import tw_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              sda_q,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              ld_stb_o,
    output logic [ADDR_W-1:0] ld_addr_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic              commit_o
);
    localparam int HI_W = ADDR_W - BYTE_W;

    eng_state_t        state, nxt;
    logic [3:0]        cnt;
    logic              ack_slot, wrote;
    logic [BYTE_W-1:0] rx, tx;
    logic [HI_W-1:0]   hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  nxt <= ST_IDLE;
            cnt <= '0;  ack_slot <= 1'b0;  wrote <= 1'b0;
            rx <= '0;  tx <= '0;  hi_q <= '0;
            sda_oe_o <= 1'b0;  ld_stb_o <= 1'b0;  ld_addr_o <= '0;
            wr_stb_o <= 1'b0;  wr_data_o <= '0;
            rd_req_o <= 1'b0;  commit_o <= 1'b0;
        end else begin
            ld_stb_o <= 1'b0;  wr_stb_o <= 1'b0;
            rd_req_o <= 1'b0;  commit_o <= 1'b0;
            if (ev.start) begin
                state <= ST_HDR;  cnt <= '0;  ack_slot <= 1'b0;
                sda_oe_o <= 1'b0;  wrote <= 1'b0;
            end else if (ev.stop) begin
                commit_o <= wrote;
                state <= ST_IDLE;  ack_slot <= 1'b0;
                sda_oe_o <= 1'b0;  wrote <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE, ST_HOLD: sda_oe_o <= 1'b0;
                    ST_RDAT: begin
                        if (!ack_slot) begin
                            if (ev.fall) begin
                                if (cnt == 4'd8) begin
                                    sda_oe_o <= 1'b0;  ack_slot <= 1'b1;
                                end else begin
                                    tx <= {tx[BYTE_W-2:0], 1'b0};
                                    sda_oe_o <= ~tx[BYTE_W-2];
                                    cnt <= cnt + 4'd1;
                                end
                            end
                        end else if (ev.rise) begin
                            if (sda_q) begin
                                state <= ST_HOLD;  ack_slot <= 1'b0;
                            end else begin
                                rd_req_o <= 1'b1;
                            end
                        end else if (ev.fall) begin
                            tx <= rd_data_i;  sda_oe_o <= ~rd_data_i[BYTE_W-1];
                            cnt <= 4'd1;  ack_slot <= 1'b0;
                        end
                    end
                    default: begin
                        if (!ack_slot) begin
                            if (ev.rise && cnt != 4'd8) begin
                                rx  <= {rx[BYTE_W-2:0], sda_q};
                                cnt <= cnt + 4'd1;
                            end else if (ev.fall && cnt == 4'd8) begin
                                ack_slot <= 1'b1;
                                sda_oe_o <= 1'b1;
                                case (state)
                                    ST_HDR: begin
                                        if (hdr_match(rx, sel_i) && !busy_i) begin
                                            rd_req_o <= rx[0];
                                            nxt <= rx[0] ? ST_RDAT : ST_AHI;
                                        end else begin
                                            state <= ST_HOLD;  ack_slot <= 1'b0;
                                            sda_oe_o <= 1'b0;
                                        end
                                    end
                                    ST_AHI: begin
                                        hi_q <= rx[HI_W-1:0];  nxt <= ST_ALO;
                                    end
                                    ST_ALO: begin
                                        ld_stb_o <= 1'b1;  ld_addr_o <= {hi_q, rx};
                                        nxt <= ST_WDAT;
                                    end
                                    default: begin
                                        wr_stb_o <= 1'b1;  wr_data_o <= rx;
                                        wrote <= 1'b1;  nxt <= ST_WDAT;
                                    end
                                endcase
                            end
                        end else if (ev.fall) begin
                            ack_slot <= 1'b0;  state <= nxt;
                            if (nxt == ST_RDAT) begin
                                tx <= rd_data_i;  sda_oe_o <= ~rd_data_i[BYTE_W-1];
                                cnt <= 4'd1;
                            end else begin
                                sda_oe_o <= 1'b0;  cnt <= '0;
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_slave_engine.sv
module tw_slave_engine
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              ld_stb_o,
    output logic [ADDR_W-1:0] ld_addr_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_req_o,
    output logic              commit_o
);
    logic [1:0] line_q;
    logic       scl_q, sda_q;
    bus_ev_t    ev;
    logic       start_q, stop_q;

    tw_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(line_q)
    );

    assign scl_q = line_q[1];
    assign sda_q = line_q[0];

    tw_cond_detect u_cond (
        .clk(clk), .rst(rst), .scl_q(scl_q), .sda_q(sda_q), .ev(ev)
    );

    assign start_q = ev.start;
    assign stop_q  = ev.stop;

    tw_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .sda_q(sda_q), .sel_i(sel_i),
        .busy_i(busy_i), .rd_data_i(rd_data_i), .sda_oe_o(sda_oe_o),
        .ld_stb_o(ld_stb_o), .ld_addr_o(ld_addr_o), .wr_stb_o(wr_stb_o),
        .wr_data_o(wr_data_o), .rd_req_o(rd_req_o), .commit_o(commit_o)
    );
endmodule

// File: rtl/tw_slave_chk.sv
module tw_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_q,
    input logic start_q,
    input logic stop_q,
    input logic busy_i,
    input logic sda_oe_o,
    input logic ld_stb_o,
    input logic wr_stb_o,
    input logic rd_req_o,
    input logic commit_o
);
    // R10
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !$past(scl_q));
    // R11
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_stb_o, wr_stb_o, rd_req_o, commit_o}));
    // R6
    a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> $past(stop_q));
    // R9
    a_r9_busy_quiet: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !sda_oe_o);
    // R5
    a_r5_write_acked: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> sda_oe_o);
    // R1
    a_r1_start_resets: assert property (@(posedge clk) disable iff (rst)
        start_q |=> (!sda_oe_o && !commit_o));
endmodule

bind tw_slave_engine tw_slave_chk u_chk (
    .clk(clk), .rst(rst), .scl_q(scl_q), .start_q(start_q), .stop_q(stop_q),
    .busy_i(busy_i), .sda_oe_o(sda_oe_o), .ld_stb_o(ld_stb_o),
    .wr_stb_o(wr_stb_o), .rd_req_o(rd_req_o), .commit_o(commit_o)
);

// File: tb/tw_slave_engine_tb.sv
`timescale 1ns/1ps
module tw_slave_engine_tb;
    localparam int Q = 10;
    localparam int BUSY_CYC = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] sel = 3'b101;
    logic busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic sda_oe, ld_stb, wr_stb, rd_req, commit;
    logic [13:0] ld_addr;
    logic [7:0] wr_data;
    wire sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    tw_slave_engine u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sel_i(sel),
        .busy_i(busy), .rd_data_i(rd_data), .sda_oe_o(sda_oe),
        .ld_stb_o(ld_stb), .ld_addr_o(ld_addr), .wr_stb_o(wr_stb),
        .wr_data_o(wr_data), .rd_req_o(rd_req), .commit_o(commit)
    );

    // memory-side model
    logic [7:0]  mem [256];
    logic [13:0] mcnt = '0;
    int n_ld = 0, n_wr = 0, n_rd = 0, n_cm = 0, busy_cnt = 0;
    logic [13:0] last_ld = '0;
    int oe_bad = 0, strobe_bad = 0;
    logic oe_prev = 1'b0;

    always @(posedge clk) begin
        if (!rst) begin
            if (ld_stb) begin mcnt <= ld_addr; last_ld <= ld_addr; n_ld <= n_ld + 1; end
            if (wr_stb) begin
                mem[mcnt[7:0]] <= wr_data;
                mcnt <= {mcnt[13:5], mcnt[4:0] + 5'd1};
                n_wr <= n_wr + 1;
            end
            if (rd_req) begin rd_data <= mem[mcnt[7:0]]; mcnt <= mcnt + 14'd1; n_rd <= n_rd + 1; end
            if (commit) begin n_cm <= n_cm + 1; busy_cnt <= BUSY_CYC; busy <= 1'b1; end
            else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
                if (busy_cnt == 1) busy <= 1'b0;
            end
        end
    end

    // R10 / R11 monitors
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe != oe_prev && scl) oe_bad++;
            if (int'(ld_stb) + int'(wr_stb) + int'(rd_req) + int'(commit) > 1) strobe_bad++;
        end
        oe_prev = sda_oe;
    end

    int tests = 0, fails = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(Q); scl = 1'b1; qw(Q); sda_m = 1'b0; qw(Q); scl = 1'b0; qw(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(Q); scl = 1'b1; qw(Q); sda_m = 1'b1; qw(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw(Q); scl = 1'b1; qw(Q); scl = 1'b0; qw(2);
        end
        sda_m = 1'b1; qw(Q); scl = 1'b1; qw(Q/2);
        acked = ~sda_line;
        qw(Q/2); scl = 1'b0; qw(2);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b, output logic slot);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(Q); scl = 1'b1; qw(Q/2); b[i] = sda_line; qw(Q/2); scl = 1'b0; qw(2);
        end
        sda_m = ~mack; qw(Q); scl = 1'b1; qw(Q/2);
        slot = sda_oe;
        qw(Q/2); scl = 1'b0; qw(2); sda_m = 1'b1;
    endtask

    task automatic wait_idle();
        while (busy) qw(1);
        qw(Q);
    endtask

    task automatic t_reset();
        chk("R1 reset oe", sda_oe, 0);
        chk("R11 reset strobes", {ld_stb, wr_stb, rd_req, commit}, 0);
    endtask

    task automatic t_write();
        logic a; int w0 = n_wr, c0 = n_cm;
        bus_start();
        send_byte(8'hAA, a); chk("R2 write header ack", a, 1);
        send_byte(8'hC1, a); chk("R4 high addr ack", a, 1);
        send_byte(8'h23, a); chk("R4 low addr ack", a, 1);
        chk("R4 loaded address", last_ld, 14'h0123);
        send_byte(8'h5A, a); chk("R5 data0 ack", a, 1);
        send_byte(8'h3C, a); chk("R5 data1 ack", a, 1);
        chk("R5 write strobes", n_wr - w0, 2);
        chk("R5 stored byte", mem[8'h24], 8'h3C);
        chk("R6 no commit before stop", n_cm - c0, 0);
        bus_stop(); qw(4);
        chk("R6 commit on stop", n_cm - c0, 1);
    endtask

    task automatic t_busy();
        logic a; int c0 = n_cm;
        chk("R9 busy active", busy, 1);
        bus_start();
        send_byte(8'hAA, a); chk("R9 no ack while busy", a, 0);
        bus_stop(); qw(4);
        chk("R9 no commit while busy", n_cm - c0, 0);
        wait_idle();
    endtask

    task automatic t_mismatch();
        logic a; int l0 = n_ld;
        bus_start();
        send_byte(8'hA2, a); chk("R3 wrong select no ack", a, 0);
        send_byte(8'h00, a); chk("R3 later byte no ack", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'hBA, a); chk("R3 wrong type no ack", a, 0);
        bus_stop(); qw(4);
        chk("R3 no address load", n_ld - l0, 0);
    endtask

    task automatic t_set_addr();
        logic a; int c0 = n_cm;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h00, a); send_byte(8'h10, a);
        bus_stop(); qw(4);
        chk("R4 set address", last_ld, 14'h0010);
        chk("R6 no commit for address only", n_cm - c0, 0);
    endtask

    task automatic t_read();
        logic a, s; logic [7:0] d; int r0 = n_rd, c0 = n_cm;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h01, a); send_byte(8'h23, a);
        bus_start();
        send_byte(8'hAB, a); chk("R2 read header ack", a, 1);
        recv_byte(1'b1, d, s); chk("R7 first read byte", d, 8'h5A);
        recv_byte(1'b0, d, s); chk("R7 second read byte", d, 8'h3C);
        chk("R7 released in ack clock", s, 0);
        chk("R7 read requests", n_rd - r0, 2);
        recv_byte(1'b0, d, s); chk("R8 silent after nack", d, 8'hFF);
        chk("R8 no request after nack", n_rd - r0, 2);
        bus_stop(); qw(4);
        chk("R6 no commit for read", n_cm - c0, 0);
    endtask

    task automatic t_restart();
        logic a, s; logic [7:0] d; int w0 = n_wr, c0 = n_cm;
        bus_start();
        send_byte(8'hAA, a); send_byte(8'h00, a); send_byte(8'h40, a);
        send_byte(8'h77, a); chk("R5 data before restart", n_wr - w0, 1);
        bus_start();
        send_byte(8'hAB, a); chk("R1 restart header ack", a, 1);
        recv_byte(1'b0, d, s); chk("R1 read after restart", d, 8'h00);
        bus_stop(); qw(4);
        chk("R6 restart discards commit", n_cm - c0, 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        qw(4);
        t_reset();
        t_write();
        t_busy();
        t_mismatch();
        t_set_addr();
        t_read();
        t_restart();
        chk("R10 oe changes with scl low", oe_bad, 0);
        chk("R11 single strobe", strobe_bad, 0);
        done = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end
endmodule